// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation cache with sixteen entries. Each entry covers two neighbouring virtual pages, an even one and an odd one, and holds a separate physical frame, cache attribute, dirty flag and valid flag for each of the two. Every entry has its own page-size mask, so one entry can map anything from a pair of 4 KB pages to a pair of 16 MB pages. A lookup presents a 32-bit virtual address and an 8-bit address-space identifier. Within the same cycle it returns the translated physical address, the cache attribute and the hit, valid and dirty flags.

Software fills the buffer through a single write port. The port takes the index either from an explicit field or from a free-running replacement counter. A programmable count of low-numbered entries is kept out of the counter's range. These locked entries hold mappings that must never be evicted by refills.

Top module: `ptlb_top`

## Requirements
- R1: After a synchronous reset, every lookup misses, the replacement index reads 15 and the locked count is 0.
- R2: An entry matches when its stored virtual page-pair number equals the address's bits 31..13 on every bit not covered by the entry's mask, and either its global bit is set or its stored ASID equals the lookup ASID.
- R3: Mask field encoding: 0x000 = 4 KB, 0x003 = 16 KB, 0x00F = 64 KB, 0x03F = 256 KB, 0x0FF = 1 MB, 0x3FF = 4 MB, 0xFFF = 16 MB. Mask bit i excludes address bit 13+i from the compare. The physical address takes its bits above the page offset from the frame number (frame bit j is address bit 12+j) and its page-offset bits from the virtual address.
- R4: The virtual address bit just above the page offset (bit 12 for 4 KB, bit 14 for 16 KB, and so on up to bit 24 for 16 MB) selects the odd half when 1 and the even half when 0. The frame, attribute, dirty and valid of the selected half are returned.
- R5: A hit on a half whose valid flag is 0 reports hit = 1 and valid = 0, with that half's other fields.
- R6: On a miss, hit, valid and dirty are 0, and the attribute and physical address are 0.
- R7: A write changes lookup results from the next clock edge on; during the write cycle itself lookups still see the old contents. A write to an index fully replaces what that index held.
- R8: The replacement index decrements by one every clock, from 15 down to the locked count, and after reaching the locked count it returns to 15.
- R9: Loading a new locked count sets the replacement index to 15 on the same edge.
- R10: A write with the random select bit set goes to the replacement index current at that edge, which is never below the locked count, so locked entries survive random refills.
- R11: The 3-bit cache attribute is stored per half and returned unchanged (2 = uncached, 3 = non-coherent write-back, 0 = non-coherent write-through without write-allocate).
- R12: At most one entry matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Some entry matched |
| lk_valid | output | 1 | Valid flag of the selected half |
| lk_dirty | output | 1 | Dirty (writable) flag of the selected half |
| lk_attr | output | 3 | Cache attribute of the selected half |
| lk_pa | output | 32 | Translated physical address |
| wr_en | input | 1 | Write an entry on this edge |
| wr_rand | input | 1 | 1: use the replacement index, 0: use wr_idx |
| wr_idx | input | 4 | Explicit entry index |
| wr_vpn2 | input | 19 | Virtual page-pair number (address bits 31..13) |
| wr_asid | input | 8 | ASID stored with the entry |
| wr_global | input | 1 | Entry matches any ASID |
| wr_mask | input | 12 | Page-size mask |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_attr_even | input | 3 | Cache attribute of the even page |
| wr_dirty_even | input | 1 | Dirty flag of the even page |
| wr_valid_even | input | 1 | Valid flag of the even page |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_attr_odd | input | 3 | Cache attribute of the odd page |
| wr_dirty_odd | input | 1 | Dirty flag of the odd page |
| wr_valid_odd | input | 1 | Valid flag of the odd page |
| wired_we | input | 1 | Load a new locked count |
| wired_val | input | 4 | New locked count |
| repl_idx | output | 4 | Current replacement index |

## Verification
The assertions assume that software never loads two entries whose masked page-pair ranges overlap for a common ASID. They also assume that the mask only takes the seven legal patterns of R3, with bits set in adjacent pairs from the bottom. The stimulus meets both assumptions by construction. Every mapping sits in its own distinct region of the address space, all masks come from the R3 list, and an overwrite reuses the same index rather than adding a second copy. The replacement checks resynchronise by loading the locked count first, so each expected index is counted from a known edge.

// File: rtl/ptlb_pkg.sv
`timescale 1ns/1ps
package ptlb_pkg;
  // smallest page is 4 KB; mask covers six size steps of 4x (two bits each)
  localparam int PTLB_MIN_OFF = 12;
  localparam int PTLB_MASK_W  = 12;

  typedef enum logic [2:0] {
    CATTR_WT_NOALLOC = 3'd0,
    CATTR_UNCACHED   = 3'd2,
    CATTR_WB         = 3'd3
  } ptlb_cattr_e;

  // picks the address bit just above the page offset: mask+1 is one-hot there
  function automatic logic ptlb_odd_pick(input logic [PTLB_MASK_W:0]   va_sl,
                                         input logic [PTLB_MASK_W-1:0] msk);
    logic [PTLB_MASK_W:0] one_hot;
    one_hot = {1'b0, msk} + {{PTLB_MASK_W{1'b0}}, 1'b1};
    return |(va_sl & one_hot);
  endfunction
endpackage

// File: rtl/ptlb_victim.sv
`timescale 1ns/1ps
module ptlb_victim #(
  parameter int NUM_ENT = 16,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wired_we,
  input  logic [IDX_W-1:0] wired_val,
  output logic [IDX_W-1:0] rnd_idx,
  output logic [IDX_W-1:0] wired_cnt
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_ENT - 1);

  logic [IDX_W-1:0] rnd_q;
  logic [IDX_W-1:0] wired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_q   <= TOP_IDX;
      wired_q <= '0;
    end else if (wired_we) begin
      wired_q <= wired_val;
      rnd_q   <= TOP_IDX;
    end else if (rnd_q <= wired_q) begin
      rnd_q <= TOP_IDX;
    end else begin
      rnd_q <= rnd_q - 1'b1;
    end
  end

  assign rnd_idx   = rnd_q;
  assign wired_cnt = wired_q;
endmodule

// File: rtl/ptlb_cam.sv
`timescale 1ns/1ps
module ptlb_cam
  import ptlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int VPN2_W = VA_W - PTLB_MIN_OFF - 1,
  localparam int PFN_W  = PA_W - PTLB_MIN_OFF,
  localparam int HI_Z   = PA_W - PTLB_MIN_OFF - PTLB_MASK_W
) (
  input  logic                   clk,
  input  logic                   rst,
  // write side
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_sel,
  input  logic [VPN2_W-1:0]      wr_vpn2,
  input  logic [ASID_W-1:0]      wr_asid,
  input  logic                   wr_global,
  input  logic [PTLB_MASK_W-1:0] wr_mask,
  input  logic [PFN_W-1:0]       wr_pfn  [2],
  input  logic [2:0]             wr_attr [2],
  input  logic [1:0]             wr_dirty,
  input  logic [1:0]             wr_valid,
  // lookup side
  input  logic [VA_W-1:0]        lk_va,
  input  logic [ASID_W-1:0]      lk_asid,
  output logic [NUM_ENT-1:0]     hit_vec,
  output logic [PA_W-1:0]        ent_pa   [NUM_ENT],
  output logic [2:0]             ent_attr [NUM_ENT],
  output logic [NUM_ENT-1:0]     ent_dirty,
  output logic [NUM_ENT-1:0]     ent_valid
);
  // entry storage: only the occupancy flags are reset
  logic [NUM_ENT-1:0]     used_q;
  logic [NUM_ENT-1:0]     glob_q;
  logic [VPN2_W-1:0]      vpn2_q [NUM_ENT];
  logic [ASID_W-1:0]      asid_q [NUM_ENT];
  logic [PTLB_MASK_W-1:0] mask_q [NUM_ENT];
  logic [PFN_W-1:0]       pfn_q  [NUM_ENT][2];
  logic [2:0]             attr_q [NUM_ENT][2];
  logic [1:0]             dirt_q [NUM_ENT];
  logic [1:0]             vld_q  [NUM_ENT];

  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else if (wr_en) used_q[wr_sel] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn2_q[wr_sel]    <= wr_vpn2;
      asid_q[wr_sel]    <= wr_asid;
      glob_q[wr_sel]    <= wr_global;
      mask_q[wr_sel]    <= wr_mask;
      pfn_q[wr_sel][0]  <= wr_pfn[0];
      pfn_q[wr_sel][1]  <= wr_pfn[1];
      attr_q[wr_sel][0] <= wr_attr[0];
      attr_q[wr_sel][1] <= wr_attr[1];
      dirt_q[wr_sel]    <= wr_dirty;
      vld_q[wr_sel]     <= wr_valid;
    end
  end

  logic [VPN2_W-1:0]        va_vpn2;
  logic [PTLB_MASK_W:0]     va_pick;
  logic [PA_W-1:0]          va_low;
  assign va_vpn2 = lk_va[VA_W-1 -: VPN2_W];
  assign va_pick = lk_va[PTLB_MIN_OFF+PTLB_MASK_W : PTLB_MIN_OFF];
  assign va_low  = lk_va[PA_W-1:0];

  for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_ent
    logic [VPN2_W-1:0] care;
    logic              page_eq;
    logic              space_eq;
    logic              half;
    logic [PA_W-1:0]   off_m;
    logic [PA_W-1:0]   base;

    assign care     = ~{{(VPN2_W-PTLB_MASK_W){1'b0}}, mask_q[gi]};
    assign page_eq  = ((vpn2_q[gi] ^ va_vpn2) & care) == '0;
    assign space_eq = glob_q[gi] || (asid_q[gi] == lk_asid);
    assign hit_vec[gi] = used_q[gi] && page_eq && space_eq;

    assign half  = ptlb_odd_pick(va_pick, mask_q[gi]);
    assign off_m = {{HI_Z{1'b0}}, mask_q[gi], {PTLB_MIN_OFF{1'b1}}};
    assign base  = {pfn_q[gi][half], {PTLB_MIN_OFF{1'b0}}};

    assign ent_pa[gi]    = (base & ~off_m) | (va_low & off_m);
    assign ent_attr[gi]  = attr_q[gi][half];
    assign ent_dirty[gi] = dirt_q[gi][half];
    assign ent_valid[gi] = vld_q[gi][half];
  end
endmodule

// File: rtl/ptlb_resolve.sv
`timescale 1ns/1ps
module ptlb_resolve #(
  parameter int NUM_ENT = 16,
  parameter int PA_W    = 32
) (
  input  logic [NUM_ENT-1:0] hit_vec,
  input  logic [PA_W-1:0]    ent_pa   [NUM_ENT],
  input  logic [2:0]         ent_attr [NUM_ENT],
  input  logic [NUM_ENT-1:0] ent_dirty,
  input  logic [NUM_ENT-1:0] ent_valid,
  output logic               hit,
  output logic               valid,
  output logic               dirty,
  output logic [2:0]         attr,
  output logic [PA_W-1:0]    pa
);
  // hits are one-hot, so a flat AND-OR merge replaces a priority chain
  always_comb begin
    pa    = '0;
    attr  = '0;
    dirty = 1'b0;
    valid = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      pa    = pa    | (ent_pa[i]   & {PA_W{hit_vec[i]}});
      attr  = attr  | (ent_attr[i] & {3{hit_vec[i]}});
      dirty = dirty | (ent_dirty[i] & hit_vec[i]);
      valid = valid | (ent_valid[i] & hit_vec[i]);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/ptlb_top.sv
`timescale 1ns/1ps
module ptlb_top
  import ptlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int VPN2_W = VA_W - PTLB_MIN_OFF - 1,
  localparam int PFN_W  = PA_W - PTLB_MIN_OFF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [VA_W-1:0]        lk_va,
  input  logic [ASID_W-1:0]      lk_asid,
  output logic                   lk_hit,
  output logic                   lk_valid,
  output logic                   lk_dirty,
  output logic [2:0]             lk_attr,
  output logic [PA_W-1:0]        lk_pa,
  input  logic                   wr_en,
  input  logic                   wr_rand,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VPN2_W-1:0]      wr_vpn2,
  input  logic [ASID_W-1:0]      wr_asid,
  input  logic                   wr_global,
  input  logic [PTLB_MASK_W-1:0] wr_mask,
  input  logic [PFN_W-1:0]       wr_pfn_even,
  input  logic [2:0]             wr_attr_even,
  input  logic                   wr_dirty_even,
  input  logic                   wr_valid_even,
  input  logic [PFN_W-1:0]       wr_pfn_odd,
  input  logic [2:0]             wr_attr_odd,
  input  logic                   wr_dirty_odd,
  input  logic                   wr_valid_odd,
  input  logic                   wired_we,
  input  logic [IDX_W-1:0]       wired_val,
  output logic [IDX_W-1:0]       repl_idx
);
  logic [IDX_W-1:0]   rnd_idx;
  logic [IDX_W-1:0]   wired_q;
  logic [IDX_W-1:0]   wr_sel;
  logic [PFN_W-1:0]   wr_pfn  [2];
  logic [2:0]         wr_attr [2];
  logic [NUM_ENT-1:0] match_vec;
  logic [PA_W-1:0]    ent_pa   [NUM_ENT];
  logic [2:0]         ent_attr [NUM_ENT];
  logic [NUM_ENT-1:0] ent_dirty;
  logic [NUM_ENT-1:0] ent_valid;

  ptlb_victim #(.NUM_ENT(NUM_ENT)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .wired_we  (wired_we),
    .wired_val (wired_val),
    .rnd_idx   (rnd_idx),
    .wired_cnt (wired_q)
  );

  assign wr_sel     = wr_rand ? rnd_idx : wr_idx;
  assign wr_pfn[0]  = wr_pfn_even;
  assign wr_pfn[1]  = wr_pfn_odd;
  assign wr_attr[0] = wr_attr_even;
  assign wr_attr[1] = wr_attr_odd;

  ptlb_cam #(
    .NUM_ENT (NUM_ENT),
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .ASID_W  (ASID_W)
  ) u_cam (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_vpn2   (wr_vpn2),
    .wr_asid   (wr_asid),
    .wr_global (wr_global),
    .wr_mask   (wr_mask),
    .wr_pfn    (wr_pfn),
    .wr_attr   (wr_attr),
    .wr_dirty  ({wr_dirty_odd, wr_dirty_even}),
    .wr_valid  ({wr_valid_odd, wr_valid_even}),
    .lk_va     (lk_va),
    .lk_asid   (lk_asid),
    .hit_vec   (match_vec),
    .ent_pa    (ent_pa),
    .ent_attr  (ent_attr),
    .ent_dirty (ent_dirty),
    .ent_valid (ent_valid)
  );

  ptlb_resolve #(.NUM_ENT(NUM_ENT), .PA_W(PA_W)) u_resolve (
    .hit_vec   (match_vec),
    .ent_pa    (ent_pa),
    .ent_attr  (ent_attr),
    .ent_dirty (ent_dirty),
    .ent_valid (ent_valid),
    .hit       (lk_hit),
    .valid     (lk_valid),
    .dirty     (lk_dirty),
    .attr      (lk_attr),
    .pa        (lk_pa)
  );

  assign repl_idx = rnd_idx;
endmodule

// File: rtl/ptlb_chk.sv
`timescale 1ns/1ps
module ptlb_chk #(
  parameter int NUM_ENT = 16,
  parameter int PA_W    = 32,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_ENT-1:0] match_vec,
  input logic [IDX_W-1:0]   repl_idx,
  input logic [IDX_W-1:0]   wired_q,
  input logic               wired_we,
  input logic               lk_hit,
  input logic               lk_valid,
  input logic               lk_dirty,
  input logic [2:0]         lk_attr,
  input logic [PA_W-1:0]    lk_pa
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_ENT - 1);

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec)); // R12

  AST_REPL_ABOVE_WIRED: assert property (@(posedge clk) disable iff (rst)
    repl_idx >= wired_q); // R10

  AST_REPL_STEP: assert property (@(posedge clk) disable iff (rst)
    (!wired_we && repl_idx > wired_q) |=> repl_idx == $past(repl_idx) - 1'b1); // R8

  AST_REPL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!wired_we && repl_idx == wired_q) |=> repl_idx == TOP_IDX); // R8

  AST_WIRED_RELOAD: assert property (@(posedge clk) disable iff (rst)
    wired_we |=> repl_idx == TOP_IDX); // R9

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (!lk_valid && !lk_dirty && lk_attr == 3'd0 && lk_pa == '0)); // R6

  AST_VALID_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> lk_hit); // R5
endmodule

bind ptlb_top ptlb_chk #(.NUM_ENT(NUM_ENT), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .match_vec (match_vec),
  .repl_idx  (repl_idx),
  .wired_q   (wired_q),
  .wired_we  (wired_we),
  .lk_hit    (lk_hit),
  .lk_valid  (lk_valid),
  .lk_dirty  (lk_dirty),
  .lk_attr   (lk_attr),
  .lk_pa     (lk_pa)
);

// File: tb/sim_ptlb_top.sv
`timescale 1ns/1ps
module sim_ptlb_top;
  import ptlb_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit, lk_valid, lk_dirty;
  logic [2:0]  lk_attr;
  logic [31:0] lk_pa;
  logic        wr_en = 1'b0, wr_rand = 1'b0, wr_global = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic [11:0] wr_mask = '0;
  logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [2:0]  wr_attr_even = '0, wr_attr_odd = '0;
  logic        wr_dirty_even = 1'b0, wr_valid_even = 1'b0;
  logic        wr_dirty_odd = 1'b0, wr_valid_odd = 1'b0;
  logic        wired_we = 1'b0;
  logic [3:0]  wired_val = '0;
  logic [3:0]  repl_idx;

  always #10 clk = ~clk;

  ptlb_top u0 (
    .clk(clk), .rst(rst), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .lk_attr(lk_attr), .lk_pa(lk_pa),
    .wr_en(wr_en), .wr_rand(wr_rand), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_mask(wr_mask),
    .wr_pfn_even(wr_pfn_even), .wr_attr_even(wr_attr_even),
    .wr_dirty_even(wr_dirty_even), .wr_valid_even(wr_valid_even),
    .wr_pfn_odd(wr_pfn_odd), .wr_attr_odd(wr_attr_odd),
    .wr_dirty_odd(wr_dirty_odd), .wr_valid_odd(wr_valid_odd),
    .wired_we(wired_we), .wired_val(wired_val), .repl_idx(repl_idx)
  );

  typedef struct {
    bit          is_repl;
    logic [3:0]  repl;
    logic [37:0] look;   // {hit, valid, dirty, attr, pa}
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // monitor: samples a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (it.is_repl) begin
          if (repl_idx !== it.repl) begin
            n_bad++;
            $display("FAIL %s: repl_idx got %0d exp %0d", it.tag, repl_idx, it.repl);
          end
        end else if ({lk_hit, lk_valid, lk_dirty, lk_attr, lk_pa} !== it.look) begin
          n_bad++;
          $display("FAIL %s: {hit,valid,dirty,attr,pa} got %b%b%b %0d %h exp %b%b%b %0d %h",
                   it.tag, lk_hit, lk_valid, lk_dirty, lk_attr, lk_pa,
                   it.look[37], it.look[36], it.look[35], it.look[34:32], it.look[31:0]);
        end
      end
    end
  end

  function automatic void push_look(bit h, bit v, bit d, logic [2:0] a,
                                    logic [31:0] pa, string tag);
    item_t it;
    it.is_repl = 1'b0;
    it.repl    = '0;
    it.look    = {h, v, d, a, pa};
    it.tag     = tag;
    sb_q.push_back(it);
  endfunction

  task automatic step();
    @(negedge clk);
    wr_en    = 1'b0;
    wired_we = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, bit h, bit v, bit d,
                      logic [2:0] a, logic [31:0] pa, string tag);
    step();
    lk_va   = va;
    lk_asid = asid;
    push_look(h, v, d, a, pa, tag);
  endtask

  task automatic exp_repl(logic [3:0] r, string tag);
    item_t it;
    step();
    it.is_repl = 1'b1;
    it.repl    = r;
    it.look    = '0;
    it.tag     = tag;
    sb_q.push_back(it);
  endtask

  task automatic set_wired(logic [3:0] w);
    step();
    wired_we  = 1'b1;
    wired_val = w;
  endtask

  task automatic load(bit rnd, logic [3:0] idx, logic [31:0] va, logic [7:0] asid,
                      bit g, logic [11:0] msk,
                      logic [19:0] pe, logic [2:0] ae, bit de, bit ve,
                      logic [19:0] po, logic [2:0] ao, bit dd, bit vo);
    step();
    wr_en = 1'b1;       wr_rand = rnd;      wr_idx = idx;
    wr_vpn2 = va[31:13]; wr_asid = asid;    wr_global = g;  wr_mask = msk;
    wr_pfn_even = pe;   wr_attr_even = ae;  wr_dirty_even = de; wr_valid_even = ve;
    wr_pfn_odd = po;    wr_attr_odd = ao;   wr_dirty_odd = dd;  wr_valid_odd = vo;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    rst = 1'b0;
    begin
      item_t it;
      it.is_repl = 1'b1; it.repl = 4'd15; it.look = '0; it.tag = "R1 repl after reset";
      sb_q.push_back(it);
    end
    look(32'h0000_0000, 8'h00, 0, 0, 0, 3'd0, 32'h0, "R1 empty lookup misses");

    // 4 KB entry at index 3 (R2, R4, R11)
    load(0, 4'd3, 32'h0040_0000, 8'h05, 0, 12'h000,
         20'h12345, CATTR_WB, 1, 1, 20'h0ABCD, CATTR_UNCACHED, 0, 1);
    look(32'h0040_0ABC, 8'h05, 1, 1, 1, CATTR_WB, 32'h1234_5ABC, "R2 R4 R11 even half");
    look(32'h0040_1123, 8'h05, 1, 1, 0, CATTR_UNCACHED, 32'h0ABC_D123, "R4 R11 odd half");
    look(32'h0040_0ABC, 8'h06, 0, 0, 0, 3'd0, 32'h0, "R2 R6 asid mismatch");
    look(32'h0040_2000, 8'h05, 0, 0, 0, 3'd0, 32'h0, "R2 R6 next pair misses");

    // 1 MB global entry at index 7 (R3, R5)
    load(0, 4'd7, 32'h1000_0000, 8'h00, 1, 12'h0FF,
         20'h555FF, CATTR_UNCACHED, 0, 1, 20'h77700, CATTR_WB, 1, 0);
    look(32'h100A_BCDE, 8'h33, 1, 1, 0, CATTR_UNCACHED, 32'h555A_BCDE, "R2 R3 global 1MB even");
    look(32'h1012_3456, 8'h33, 1, 0, 1, CATTR_WB, 32'h7772_3456, "R5 hit on invalid odd half");
    look(32'h1020_0000, 8'h33, 0, 0, 0, 3'd0, 32'h0, "R3 outside 1MB pair");

    // 16 MB entry at index 9 (R3)
    load(0, 4'd9, 32'h4000_0000, 8'h05, 0, 12'hFFF,
         20'hAB000, CATTR_WT_NOALLOC, 1, 1, 20'hCD000, CATTR_WB, 0, 1);
    look(32'h40FE_DCBA, 8'h05, 1, 1, 1, CATTR_WT_NOALLOC, 32'hABFE_DCBA, "R3 R11 16MB even");
    look(32'h4100_0010, 8'h05, 1, 1, 0, CATTR_WB, 32'hCD00_0010, "R3 R4 16MB odd");
    look(32'h4200_0000, 8'h05, 0, 0, 0, 3'd0, 32'h0, "R3 outside 16MB pair");

    // 16 KB entry at index 2 (R3, R4)
    load(0, 4'd2, 32'h0080_0000, 8'h05, 0, 12'h003,
         20'h20000, CATTR_WB, 0, 1, 20'h30004, CATTR_UNCACHED, 1, 1);
    look(32'h0080_2345, 8'h05, 1, 1, 0, CATTR_WB, 32'h2000_2345, "R3 R4 16KB even");
    look(32'h0080_6001, 8'h05, 1, 1, 1, CATTR_UNCACHED, 32'h3000_6001, "R3 R4 16KB odd");

    // R7 overwrite of index 3: old contents visible during the write cycle
    look(32'h0040_0ABC, 8'h05, 1, 1, 1, CATTR_WB, 32'h1234_5ABC, "R7 before overwrite");
    load(0, 4'd3, 32'h0060_0000, 8'h05, 0, 12'h000,
         20'h11111, CATTR_WB, 0, 1, 20'h22222, CATTR_WB, 0, 1);
    push_look(1, 1, 1, CATTR_WB, 32'h1234_5ABC, "R7 old entry during write cycle");
    look(32'h0040_0ABC, 8'h05, 0, 0, 0, 3'd0, 32'h0, "R7 old mapping gone");
    look(32'h0060_0010, 8'h05, 1, 1, 0, CATTR_WB, 32'h1111_1010, "R7 new mapping");

    // R8 R9 replacement sequence
    set_wired(4'd14);
    exp_repl(4'd15, "R9 reload after wired write");
    exp_repl(4'd14, "R8 step to wired");
    exp_repl(4'd15, "R8 wrap at wired");
    exp_repl(4'd14, "R8 step again");
    set_wired(4'd12);
    exp_repl(4'd15, "R9 reload 12");
    exp_repl(4'd14, "R8 step 14");
    exp_repl(4'd13, "R8 step 13");
    exp_repl(4'd12, "R8 step 12");
    exp_repl(4'd15, "R8 wrap 12");

    // R10 random refills with locked count 14
    set_wired(4'd14);
    load(1, 4'd0, 32'h7000_0000, 8'h01, 0, 12'h000,
         20'hB0000, CATTR_WB, 0, 1, 20'hB0001, CATTR_WB, 0, 1);
    load(1, 4'd0, 32'h7100_0000, 8'h01, 0, 12'h000,
         20'hC0000, CATTR_WB, 0, 1, 20'hC0001, CATTR_WB, 0, 1);
    load(1, 4'd0, 32'h7200_0000, 8'h01, 0, 12'h000,
         20'hD0000, CATTR_WB, 0, 1, 20'hD0001, CATTR_WB, 0, 1);
    look(32'h7000_0000, 8'h01, 0, 0, 0, 3'd0, 32'h0, "R10 first refill evicted by third");
    look(32'h7100_0004, 8'h01, 1, 1, 0, CATTR_WB, 32'hC000_0004, "R10 second refill kept");
    look(32'h7200_1008, 8'h01, 1, 1, 0, CATTR_WB, 32'hD000_1008, "R10 third refill");
    look(32'h0060_0010, 8'h05, 1, 1, 0, CATTR_WB, 32'h1111_1010, "R10 locked index 3 intact");
    look(32'h40FE_DCBA, 8'h05, 1, 1, 1, CATTR_WT_NOALLOC, 32'hABFE_DCBA, "R10 locked index 9 intact");

    step();
    step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule